// File: doc/BRIEF.md
# Load/Store Bus Adapter

This block connects a processor core's memory request port to a 32-bit external data bus. The core presents one request at a time. Each request carries a byte address, a 4-bit operation code and store data. The adapter turns the request into a single bus transaction. It waits for the bus to signal ready, then returns an acknowledge pulse with the load result already formatted to 32 bits.

For stores, the adapter places the store value on every byte lane it could reach and derives the byte strobes from the low address bits. For loads, it picks the addressed byte or halfword out of the returned word and then sign- or zero-extends it. Halfword and word accesses have their low address bits forced to zero before they go out on the bus, so the bus never sees an unaligned halfword or word.

Top module: `lsu_bus_adapter`

## Requirements
- R1: The operation code is decoded by field. Bit 3 set means store and bit 3 clear means load. Bits [1:0] give the size: 0 for byte, 1 for halfword, 2 for word. Bit 2 set marks an unsigned load. The eight codes are 0x0 signed byte load, 0x1 signed halfword load, 0x2 word load, 0x4 unsigned byte load, 0x5 unsigned halfword load, 0x8 byte store, 0x9 halfword store and 0xA word store. bus_write is 1 for the three stores and 0 for the five loads.
- R2: The bus address equals the request address, except that bit 0 is cleared for halfword accesses and bits [1:0] are cleared for word accesses.
- R3: For a byte store, bus_strb is 4'b0001 shifted left by bus_addr[1:0], and bus_wdata is store byte [7:0] copied into all four lanes.
- R4: For a halfword store, bus_strb is 4'b0011 shifted left by bus_addr[1:0], and bus_wdata is store halfword [15:0] copied into both halves.
- R5: For a word store, bus_strb is 4'hF and bus_wdata is the full store value.
- R6: Signed byte and halfword loads return the addressed byte or halfword, sign-extended to 32 bits. The byte is at bus_rdata bits [8*bus_addr[1:0] +: 8]. The halfword is the upper half when bus_addr[1] is 1 and the lower half otherwise.
- R7: Unsigned byte and halfword loads return the same field, zero-extended to 32 bits. A word load returns bus_rdata unchanged.
- R8: bus_valid rises in the cycle after a request is accepted. While bus_ready is low, bus_valid, bus_addr, bus_wdata, bus_strb and bus_write hold steady. bus_valid drops in the cycle after bus_ready is sampled high.
- R9: ack_valid is a one-cycle pulse in the cycle after bus_ready is sampled high with bus_valid. It is never high together with bus_valid.
- R10: A request is accepted only while the adapter is idle. A req_valid raised during a bus transaction, or in the acknowledge cycle, is ignored: the bus fields do not change and no second transaction follows.
- R11: A synchronous active-high reset returns the adapter to idle with bus_valid and ack_valid low. This holds even in the middle of a transaction.
- R12: ack_data is computed from bus_rdata as sampled on the ready edge. Later changes on bus_rdata do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_addr | input | ADDR_W | Request byte address |
| req_op | input | 4 | Operation code |
| req_wdata | input | 32 | Store value |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_data | output | 32 | Formatted load result |
| bus_valid | output | 1 | Bus transaction active |
| bus_addr | output | ADDR_W | Bus byte address (aligned for halfword and word) |
| bus_wdata | output | 32 | Bus write data |
| bus_strb | output | 4 | Byte lane strobes |
| bus_write | output | 1 | 1 for store, 0 for load |
| bus_rdata | input | 32 | Bus read data |
| bus_ready | input | 1 | Bus transaction complete |

## Verification
The assertions assume the following about the inputs:
- The request operation code is one of the eight listed codes, so that the size field the alignment and strobe properties decode has a meaning.
- bus_ready is only meaningful while bus_valid is high.

The stimulus stays within these limits. It draws operation codes only from the eight-entry list. It raises bus_ready only while a transaction is open, after zero to three random wait cycles. Extra req_valid pulses are injected only to show that they are ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int XLEN  = 32;
    localparam int NLANE = XLEN / 8;
    localparam int OFFW  = $clog2(NLANE);
    localparam int CODEW = 4;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      is_store;
        logic      is_signed;
        acc_size_e size;
    } op_info_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_ACK
    } seq_state_e;

    // Field decode: bit3 store, bit2 unsigned, bits[1:0] size
    function automatic op_info_t decode_op(logic [CODEW-1:0] code);
        op_info_t info;
        info.is_store  = code[3];
        info.is_signed = ~code[2];
        case (code[1:0])
            2'd0:    info.size = SZ_B;
            2'd1:    info.size = SZ_H;
            default: info.size = SZ_W;
        endcase
        return info;
    endfunction

    function automatic logic [NLANE-1:0] lane_mask(acc_size_e sz, logic [OFFW-1:0] off);
        case (sz)
            SZ_B:    return NLANE'(1) << off;
            SZ_H:    return NLANE'(3) << off;
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODEW-1:0]  code,
    input  logic [XLEN-1:0]   data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [XLEN-1:0]   wdata,
    output logic [NLANE-1:0]  strb,
    output logic              write
);
    op_info_t        info;
    logic [OFFW-1:0] off;

    assign info = decode_op(code);

    always_comb begin
        bus_addr = addr;
        case (info.size)
            SZ_B:    bus_addr = addr;
            SZ_H:    bus_addr[0] = 1'b0;
            default: bus_addr[OFFW-1:0] = '0;
        endcase
    end

    assign off   = bus_addr[OFFW-1:0];
    assign write = info.is_store;
    assign strb  = info.is_store ? lane_mask(info.size, off) : '0;

    // Per-lane fan-out of store data
    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            logic [7:0] lane_byte;
            assign lane_byte = (info.size == SZ_B) ? data[7:0] :
                               (info.size == SZ_H) ? data[8*(i%2) +: 8] :
                                                     data[8*i +: 8];
            assign wdata[8*i +: 8] = lane_byte;
        end
    endgenerate
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [CODEW-1:0] code,
    input  logic [OFFW-1:0]  off,
    input  logic [XLEN-1:0]  raw,
    output logic [XLEN-1:0]  result
);
    op_info_t        info;
    logic [XLEN-1:0] shifted;

    assign info    = decode_op(code);
    assign shifted = raw >> {off, 3'b000};

    always_comb begin
        case (info.size)
            SZ_B:    result = {{(XLEN-8){info.is_signed & shifted[7]}}, shifted[7:0]};
            SZ_H:    result = {{(XLEN-16){info.is_signed & shifted[15]}}, shifted[15:0]};
            default: result = raw;
        endcase
    end
endmodule

// File: rtl/lsu_bus_seq.sv
module lsu_bus_seq
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODEW-1:0]  req_op,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [XLEN-1:0]   nxt_wdata,
    input  logic [NLANE-1:0]  nxt_strb,
    input  logic              nxt_write,
    input  logic              bus_ready,
    input  logic [XLEN-1:0]   load_result,
    output logic [CODEW-1:0]  op_q,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [XLEN-1:0]   bus_wdata,
    output logic [NLANE-1:0]  bus_strb,
    output logic              bus_write,
    output logic              ack_valid,
    output logic [XLEN-1:0]   ack_data
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            bus_valid <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_strb  <= '0;
            bus_write <= 1'b0;
            ack_valid <= 1'b0;
            ack_data  <= '0;
        end else begin
            ack_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q      <= req_op;
                        bus_addr  <= nxt_addr;
                        bus_wdata <= nxt_wdata;
                        bus_strb  <= nxt_strb;
                        bus_write <= nxt_write;
                        bus_valid <= 1'b1;
                        state     <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (bus_ready) begin
                        bus_valid <= 1'b0;
                        ack_data  <= load_result;
                        ack_valid <= 1'b1;
                        state     <= ST_ACK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    op_info_t held;
    assign held = decode_op(op_q);

    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                       && $stable(bus_strb) && $stable(bus_write)));
    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> !bus_valid);
    assert_ack_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> ack_valid);
    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid);
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !bus_valid);
    assert_write_flag_R1: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_write == held.is_store));
    assert_half_align_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && held.size == SZ_H) |-> !bus_addr[0]);
    assert_word_align_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && held.size == SZ_W) |-> (bus_addr[OFFW-1:0] == '0));
    assert_byte_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && held.size == SZ_B) |-> ($countones(bus_strb) == 1));
    assert_word_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && held.size == SZ_W) |-> (bus_strb == '1));
endmodule

// File: rtl/lsu_bus_adapter.sv
module lsu_bus_adapter
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_op,
    input  logic [31:0]       req_wdata,
    output logic              ack_valid,
    output logic [31:0]       ack_data,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_strb,
    output logic              bus_write,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready
);
    logic [ADDR_W-1:0] nxt_addr;
    logic [XLEN-1:0]   nxt_wdata;
    logic [NLANE-1:0]  nxt_strb;
    logic              nxt_write;
    logic [CODEW-1:0]  op_q;
    logic [XLEN-1:0]   load_result;

    lsu_store_lanes #(.ADDR_W(ADDR_W)) u_store (
        .addr     (req_addr),
        .code     (req_op),
        .data     (req_wdata),
        .bus_addr (nxt_addr),
        .wdata    (nxt_wdata),
        .strb     (nxt_strb),
        .write    (nxt_write)
    );

    lsu_load_extract u_load (
        .code   (op_q),
        .off    (bus_addr[OFFW-1:0]),
        .raw    (bus_rdata),
        .result (load_result)
    );

    lsu_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .nxt_addr    (nxt_addr),
        .nxt_wdata   (nxt_wdata),
        .nxt_strb    (nxt_strb),
        .nxt_write   (nxt_write),
        .bus_ready   (bus_ready),
        .load_result (load_result),
        .op_q        (op_q),
        .bus_valid   (bus_valid),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_strb    (bus_strb),
        .bus_write   (bus_write),
        .ack_valid   (ack_valid),
        .ack_data    (ack_data)
    );
endmodule

// File: tb/sim_lsu_bus_adapter.sv
module sim_lsu_bus_adapter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [3:0]  req_op;
    logic [31:0] req_wdata;
    logic        ack_valid;
    logic [31:0] ack_data;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_strb;
    logic        bus_write;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_bus_adapter u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_wdata(req_wdata), .ack_valid(ack_valid),
        .ack_data(ack_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_write(bus_write),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [3:0] op, logic [31:0] a);
        case (op[1:0])
            2'd0:    return a;
            2'd1:    return {a[31:1], 1'b0};
            default: return {a[31:2], 2'b00};
        endcase
    endfunction

    function automatic logic [3:0] exp_strb(logic [3:0] op, logic [31:0] ea);
        case (op)
            4'h8:    return 4'b0001 << ea[1:0];
            4'h9:    return 4'b0011 << ea[1:0];
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [31:0] exp_wdata(logic [3:0] op, logic [31:0] d);
        case (op)
            4'h8:    return {d[7:0], d[7:0], d[7:0], d[7:0]};
            4'h9:    return {d[15:0], d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_load(logic [3:0] op, logic [31:0] ea, logic [31:0] rd);
        logic [7:0]  b;
        logic [15:0] h;
        b = rd[8*ea[1:0] +: 8];
        h = ea[1] ? rd[31:16] : rd[15:0];
        case (op)
            4'h0:    return {{24{b[7]}}, b};
            4'h4:    return {24'h0, b};
            4'h1:    return {{16{h[15]}}, h};
            4'h5:    return {16'h0, h};
            default: return rd;
        endcase
    endfunction

    function automatic string store_tag(logic [3:0] op);
        case (op)
            4'h8:    return "R3 store";
            4'h9:    return "R4 store";
            default: return "R5 store";
        endcase
    endfunction

    task automatic run_txn(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                           input logic [31:0] rd, input int waits, input bit poke);
        logic [31:0] ea;
        ea = exp_addr(op, a);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk("R8 valid issued", {31'b0, bus_valid}, 32'd1);
        chk("R2 address", bus_addr, ea);
        chk("R1 write flag", {31'b0, bus_write}, {31'b0, op[3]});
        if (op[3]) begin
            chk({store_tag(op), " strobe"}, {28'b0, bus_strb}, {28'b0, exp_strb(op, ea)});
            chk({store_tag(op), " data"}, bus_wdata, exp_wdata(op, d));
        end
        for (int i = 0; i < waits; i++) begin
            if (poke && i == 0) begin
                req_valid = 1'b1; req_addr = a ^ 32'h40; req_op = op ^ 4'h8;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 hold valid", {31'b0, bus_valid}, 32'd1);
            chk("R10 busy addr unchanged", bus_addr, ea);
            chk("R8 hold write", {31'b0, bus_write}, {31'b0, op[3]});
        end
        bus_ready = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ready = 1'b0; bus_rdata = ~rd;
        #1;
        chk("R9 ack pulse", {31'b0, ack_valid}, 32'd1);
        chk("R8 valid dropped", {31'b0, bus_valid}, 32'd0);
        if (!op[3])
            chk((op == 4'h0 || op == 4'h1) ? "R6 signed load R12" : "R7 unsigned load R12",
                ack_data, exp_load(op, ea, rd));
        if (poke) begin
            req_valid = 1'b1; req_addr = a ^ 32'h80;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ack single cycle", {31'b0, ack_valid}, 32'd0);
        chk("R10 no extra transaction", {31'b0, bus_valid}, 32'd0);
    endtask

    initial begin
        logic [3:0] codes [8];
        codes[0] = 4'h0; codes[1] = 4'h1; codes[2] = 4'h2; codes[3] = 4'h4;
        codes[4] = 4'h5; codes[5] = 4'h8; codes[6] = 4'h9; codes[7] = 4'hA;
        void'($urandom(32'h5eed_1234));

        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_op = '0; req_wdata = '0;
        bus_rdata = '0; bus_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 reset valid", {31'b0, bus_valid}, 32'd0);
        chk("R11 reset ack", {31'b0, ack_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed: every op at every offset, two read patterns
        for (int k = 0; k < 8; k++) begin
            for (int o = 0; o < 4; o++) begin
                run_txn(codes[k], 32'h0000_1000 + o, 32'hC3A5_96E1, 32'h8A7B_F36C, o % 3, 1'b0);
                run_txn(codes[k], 32'h0000_2000 + o, 32'h1234_5678, 32'h7F80_01FF, 0, 1'b0);
            end
        end

        // Reset in mid transaction
        req_valid = 1'b1; req_op = 4'h2; req_addr = 32'h300; req_wdata = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 pre-reset valid", {31'b0, bus_valid}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 mid reset valid", {31'b0, bus_valid}, 32'd0);
        chk("R11 mid reset ack", {31'b0, ack_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Random transactions
        for (int n = 0; n < 400; n++) begin
            run_txn(codes[$urandom % 8], $urandom, $urandom, $urandom,
                    int'($urandom % 4), bit'($urandom % 2));
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule